// File: doc/BRIEF.md
# Compact 8-bit Accumulator Processor Core

This block is a small multi-cycle processor with two 8-bit working registers (A and B), an 8-bit instruction pointer, and carry and zero flags. It drives one 8-bit address bus, reads through a data-in bus, writes through a data-out bus with a write strobe, and expects memory to return read data combinationally within the same cycle.

Every instruction takes exactly two cycles. The first cycle fetches the opcode. The second cycle executes it, and if the opcode needs an extra byte (an immediate value, a memory operand or a branch target), that byte is read in the same second cycle.

Most of the instruction set is one ALU instruction with a 4-bit operation code, a 2-bit destination field and a 2-bit operand-source field. The destination can be A, B, the instruction pointer or a discard slot that keeps only the flags. Loads and jumps are therefore just the "pass second operand" operation aimed at the right destination. The remaining opcodes cover a short-address store, a register swap, a carry clear, a soft reset and flag-conditional branches.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high the core keeps `bus_we` low. After `rst` falls, the first cycle is a fetch from address 0. A, B, the instruction pointer and both flags start at 0.
- R2: An opcode `00 dd oooo` applies ALU operation `oooo` with A as the first operand and B as the second. Field `dd` chooses the destination: 0 = A, 1 = B, 2 = instruction pointer, 3 = discard. With discard, only the flags change.
- R3: The ALU operation codes are:
  - 0 gives A; 1 gives the second operand; 2 gives second+1; 3 gives second-1.
  - 4 gives OR; 5 gives AND; 6 gives XOR; 7 gives 0.
  - 8 gives A+second; 9 gives A-second.
  - 10 shifts the second operand left; 11 shifts it right logically.
  - 12 gives A+second+carry; 13 gives A-second-carry.
  - 14 rotates the second operand left through carry; 15 rotates it right through carry.
  - All results are taken modulo 256.
- R4: Every ALU operation sets the zero flag exactly when its 8-bit result is 0. Carry is set as follows:
  - codes 2, 8 and 12: the adder carry-out;
  - codes 3, 9 and 13: the borrow;
  - the shifts and rotates: the bit shifted out;
  - codes 0, 1 and 4 to 7: carry is left unchanged.
- R5: An opcode `01 dd oooo` uses the byte after the opcode as the second operand, and execution continues after that byte. When `dd` = 2, the ALU result becomes the instruction pointer and overrides the step past the operand. Byte 0x61 is therefore a jump.
- R6: An opcode `11 dd oooo` uses the memory byte at the address held in B as the second operand.
- R7: The opcode `1001 aaaa` writes A to address `0000aaaa`. The write strobe is high for one cycle only.
- R8: Opcode 0x81 exchanges A and B. Opcode 0x88 clears carry without touching A or B.
- R9: Opcode 0x8F clears A, B, the instruction pointer and both flags, so execution restarts at address 0.
- R10: The opcode `1010 cccc` is followed by a target byte. Condition code 0x1 branches on carry clear, 0x3 on carry set, 0x4 on zero set and 0xC on zero clear. A taken branch loads the target. A branch that is not taken continues after the target byte.
- R11: Each instruction spends one fetch cycle, with the address equal to the instruction pointer, followed by one execute cycle. The pointer has advanced by one when the execute cycle begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | output | 8 | Memory address for the current cycle |
| bus_rdata | input | 8 | Read data for `bus_addr`, valid in the same cycle |
| bus_wdata | output | 8 | Write data (register A) |
| bus_we | output | 1 | Write strobe; memory writes `bus_wdata` at `bus_addr` on the clock edge |

## Verification
The sensitive coincidence is inside one execute cycle: reading an operand byte advances the instruction pointer while an ALU result or a branch target is also written to it. A branch makes a similar choice between its target and the step past it. Every jump, every taken and untaken branch and the register-indirect jump provoke this coincidence. Each is judged by where execution lands, made visible by marker stores that only the correct path executes, and by the bus address sequence right after reset. The full ALU table is swept over all 16 operations, eight operand pairs and both carry inputs, and the result and both flags are stored to memory for arithmetic comparison.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int DW  = 8;   // data and address width
  localparam int ZPW = 4;   // short store address width
  localparam int OPW = 4;   // ALU operation code width

  typedef enum logic { ST_FETCH = 1'b0, ST_EXEC = 1'b1 } state_e;

  typedef enum logic [1:0] {
    D_A = 2'd0, D_B = 2'd1, D_IP = 2'd2, D_NONE = 2'd3
  } dest_e;

  typedef enum logic [OPW-1:0] {
    OP_PA, OP_PB, OP_INC, OP_DEC, OP_OR, OP_AND, OP_XOR, OP_ZERO,
    OP_ADD, OP_SUB, OP_ASL, OP_LSR, OP_ADC, OP_SBB, OP_ROL, OP_ROR
  } aop_e;

  typedef enum logic [2:0] {
    K_NONE, K_ALU, K_STORE, K_SWAP, K_CLC, K_SRST, K_BRANCH
  } kind_e;

  typedef enum logic [1:0] { SRC_B, SRC_IMM, SRC_MEM } src_e;

  typedef struct packed {
    kind_e           kind;
    src_e            src;
    dest_e           dest;
    aop_e            op;
    logic [OPW-1:0]  low;
  } dec_t;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          z;
    logic          cupd;
  } alu_out_t;

  function automatic alu_out_t alu_eval(input aop_e op, input logic [DW-1:0] a,
                                        input logic [DW-1:0] b, input logic cin);
    alu_out_t o;
    logic [DW:0] w;
    w = '0;
    o.res = '0;
    o.c = cin;
    o.cupd = 1'b1;
    case (op)
      OP_PA:   begin o.res = a;     o.cupd = 1'b0; end
      OP_PB:   begin o.res = b;     o.cupd = 1'b0; end
      OP_OR:   begin o.res = a | b; o.cupd = 1'b0; end
      OP_AND:  begin o.res = a & b; o.cupd = 1'b0; end
      OP_XOR:  begin o.res = a ^ b; o.cupd = 1'b0; end
      OP_ZERO: begin o.res = '0;    o.cupd = 1'b0; end
      OP_INC:  begin
        w = {1'b0, b} + {{DW{1'b0}}, 1'b1};
        o.res = w[DW-1:0]; o.c = w[DW];
      end
      OP_DEC:  begin
        w = {1'b0, b} - {{DW{1'b0}}, 1'b1};
        o.res = w[DW-1:0]; o.c = w[DW];
      end
      OP_ADD:  begin
        w = {1'b0, a} + {1'b0, b};
        o.res = w[DW-1:0]; o.c = w[DW];
      end
      OP_SUB:  begin
        w = {1'b0, a} - {1'b0, b};
        o.res = w[DW-1:0]; o.c = w[DW];
      end
      OP_ADC:  begin
        w = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        o.res = w[DW-1:0]; o.c = w[DW];
      end
      OP_SBB:  begin
        w = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
        o.res = w[DW-1:0]; o.c = w[DW];
      end
      OP_ASL:  begin o.res = {b[DW-2:0], 1'b0}; o.c = b[DW-1]; end
      OP_LSR:  begin o.res = {1'b0, b[DW-1:1]}; o.c = b[0];    end
      OP_ROL:  begin o.res = {b[DW-2:0], cin};  o.c = b[DW-1]; end
      OP_ROR:  begin o.res = {cin, b[DW-1:1]};  o.c = b[0];    end
      default: ;
    endcase
    o.z = (o.res == '0);
    return o;
  endfunction

  // bit0 tests carry against bit1; bit2 tests zero, bit3 inverts it
  function automatic logic branch_take(input logic [OPW-1:0] cc, input logic c,
                                       input logic z);
    return (cc[0] && (c == cc[1])) || (cc[2] && (z != cc[3]));
  endfunction
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [DW-1:0] ir,
  output dec_t          d
);
  always_comb begin
    d = '0;
    d.kind = K_NONE;
    d.src  = SRC_B;
    d.dest = dest_e'(ir[5:4]);
    d.op   = aop_e'(ir[OPW-1:0]);
    d.low  = ir[OPW-1:0];
    case (ir[7:6])
      2'b00: d.kind = K_ALU;
      2'b01: begin d.kind = K_ALU; d.src = SRC_IMM; end
      2'b11: begin d.kind = K_ALU; d.src = SRC_MEM; end
      default: begin
        case (ir[5:4])
          2'b01: d.kind = K_STORE;
          2'b10: d.kind = K_BRANCH;
          2'b00: begin
            case (ir[3:0])
              4'h1:    d.kind = K_SWAP;
              4'h8:    d.kind = K_CLC;
              4'hF:    d.kind = K_SRST;
              default: d.kind = K_NONE;
            endcase
          end
          default: d.kind = K_NONE;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
(
  input  aop_e          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          zero,
  output logic          cupd
);
  alu_out_t o;
  assign o    = alu_eval(op, a, b, cin);
  assign res  = o.res;
  assign cout = o.c;
  assign zero = o.z;
  assign cupd = o.cupd;
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] bus_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we
);
  state_e        st;
  logic [DW-1:0] ir, ip, ra, rb;
  logic          cf, zf;
  dec_t          dec;
  logic [DW-1:0] operand, alu_res, ip_inc;
  logic          alu_c, alu_z, alu_cupd;

  acc8_decode u_dec (.ir(ir), .d(dec));

  assign operand = (dec.src == SRC_B) ? rb : bus_rdata;
  assign ip_inc  = ip + {{(DW-1){1'b0}}, 1'b1};

  acc8_alu u_alu (
    .op(dec.op), .a(ra), .b(operand), .cin(cf),
    .res(alu_res), .cout(alu_c), .zero(alu_z), .cupd(alu_cupd)
  );

  // named events
  logic ev_exec, ev_alu, ev_store, ev_srst, ev_branch, ev_taken, ev_imm_jump;
  assign ev_exec     = (st == ST_EXEC);
  assign ev_alu      = ev_exec && (dec.kind == K_ALU);
  assign ev_store    = ev_exec && (dec.kind == K_STORE);
  assign ev_srst     = ev_exec && (dec.kind == K_SRST);
  assign ev_branch   = ev_exec && (dec.kind == K_BRANCH);
  assign ev_taken    = ev_branch && branch_take(dec.low, cf, zf);
  assign ev_imm_jump = ev_alu && (dec.src == SRC_IMM) && (dec.dest == D_IP);

  always_comb begin
    bus_addr = ip;
    if (ev_store)
      bus_addr = {{(DW-ZPW){1'b0}}, ir[ZPW-1:0]};
    else if (ev_alu && dec.src == SRC_MEM)
      bus_addr = rb;
  end

  assign bus_wdata = ra;
  assign bus_we    = ev_store;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_FETCH;
      ir <= '0;
      ip <= '0;
      ra <= '0;
      rb <= '0;
      cf <= 1'b0;
      zf <= 1'b0;
    end else if (st == ST_FETCH) begin
      ir <= bus_rdata;
      ip <= ip_inc;
      st <= ST_EXEC;
    end else begin
      st <= ST_FETCH;
      case (dec.kind)
        K_ALU: begin
          cf <= alu_c;
          zf <= alu_z;
          if (dec.src == SRC_IMM) ip <= ip_inc;
          case (dec.dest)
            D_A:     ra <= alu_res;
            D_B:     rb <= alu_res;
            D_IP:    ip <= alu_res;
            default: ;
          endcase
        end
        K_SWAP: begin
          ra <= rb;
          rb <= ra;
        end
        K_CLC: cf <= 1'b0;
        K_SRST: begin
          ip <= '0;
          ra <= '0;
          rb <= '0;
          cf <= 1'b0;
          zf <= 1'b0;
        end
        K_BRANCH: ip <= ev_taken ? bus_rdata : ip_inc;
        default: ;
      endcase
    end
  end

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst) (st == ST_FETCH) |=> (ev_exec && ip == $past(ip) + 8'd1)); // R11
  AST_DISCARD_HOLDS: assert property (@(posedge clk) disable iff (rst) (ev_alu && dec.dest == D_NONE) |=> (ra == $past(ra) && rb == $past(rb))); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst) ev_alu |=> (zf == ($past(alu_res) == '0))); // R4
  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (rst) (ev_alu && !alu_cupd) |=> (cf == $past(cf))); // R4
  AST_IMM_JUMP: assert property (@(posedge clk) disable iff (rst) ev_imm_jump |=> (ip == $past(alu_res))); // R5
  AST_MEM_OPERAND: assert property (@(posedge clk) disable iff (rst) (ev_alu && dec.src == SRC_MEM) |-> (bus_addr == rb)); // R6
  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst) bus_we |=> !bus_we); // R7
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst) ev_srst |=> (ip == '0 && ra == '0 && rb == '0 && !cf && !zf)); // R9
  AST_BRANCH_SKIP: assert property (@(posedge clk) disable iff (rst) (ev_branch && !ev_taken) |=> (ip == $past(ip) + 8'd1)); // R10
endmodule

// File: tb/sim_acc8_core.sv
module sim_acc8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr, bus_rdata, bus_wdata;
  logic       bus_we;
  logic [7:0] mem [256];
  logic [7:0] pw;
  int         nchk = 0;
  int         nfail = 0;
  int         cyc = 0;

  always #10 clk = ~clk;

  acc8_core u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_we(bus_we)
  );

  assign bus_rdata = mem[bus_addr];
  always @(posedge clk) if (bus_we && !rst) mem[bus_addr] <= bus_wdata;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] v);
    mem[pw] = v;
    pw = pw + 8'd1;
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[0] = 8'h61;
    mem[1] = 8'h80;
    pw = 8'h80;
  endtask

  task automatic run(input int n);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // independent model: {carry, zero, result}
  function automatic logic [9:0] ref_alu(input int op, input int a, input int b, input int ci);
    int r, c;
    c = ci;
    case (op)
      0: r = a;
      1: r = b;
      2: begin r = b + 1; c = (b == 255) ? 1 : 0; end
      3: begin r = b - 1; c = (b == 0) ? 1 : 0; end
      4: r = a | b;
      5: r = a & b;
      6: r = a ^ b;
      7: r = 0;
      8: begin r = a + b; c = (r > 255) ? 1 : 0; end
      9: begin c = (a < b) ? 1 : 0; r = a - b; end
      10: begin c = b / 128; r = b * 2; end
      11: begin c = b % 2; r = b / 2; end
      12: begin r = a + b + ci; c = (r > 255) ? 1 : 0; end
      13: begin c = (a < b + ci) ? 1 : 0; r = a - b - ci; end
      14: begin c = b / 128; r = b * 2 + ci; end
      default: begin c = b % 2; r = b / 2 + ci * 128; end
    endcase
    r = r & 255;
    return {c[0], (r == 0), r[7:0]};
  endfunction

  task automatic alu_case(input int op, input logic [7:0] a, input logic [7:0] b, input int ci);
    logic [7:0] p1, p2;
    logic [9:0] e;
    hold_reset();
    if (ci != 0) begin
      emit(8'h41); emit(8'hFF); emit(8'h51); emit(8'h01); emit(8'h38);
    end else emit(8'h88);
    emit(8'h41); emit(a); emit(8'h51); emit(b);
    emit({4'h0, op[3:0]});
    emit(8'h90);
    emit(8'hA4); p1 = pw; emit(8'h00);
    emit(8'h41); emit(8'h00); emit(8'h61); p2 = pw; emit(8'h00);
    mem[p1] = pw; emit(8'h41); emit(8'h01); mem[p2] = pw;
    emit(8'h91);
    emit(8'hA1); p1 = pw; emit(8'h00);
    emit(8'h41); emit(8'h01); emit(8'h61); p2 = pw; emit(8'h00);
    mem[p1] = pw; emit(8'h41); emit(8'h00); mem[p2] = pw;
    emit(8'h92);
    p1 = pw; emit(8'h61); emit(p1);
    run(90);
    e = ref_alu(op, int'(a), int'(b), ci);
    chk($sformatf("R3 op%0d a%0h b%0h c%0d result", op, a, b, ci), mem[0], e[7:0]);
    chk($sformatf("R4 op%0d a%0h b%0h c%0d zero", op, a, b, ci), mem[1], e[8]);
    chk($sformatf("R4 op%0d a%0h b%0h c%0d carry", op, a, b, ci), mem[2], e[9]);
  endtask

  initial begin
    logic [7:0] va [8];
    logic [7:0] vb [8];
    logic [7:0] p;
    va = '{8'h00, 8'hFF, 8'h80, 8'h5A, 8'h01, 8'h7F, 8'h00, 8'hC3};
    vb = '{8'h00, 8'h01, 8'h80, 8'hA5, 8'hFF, 8'h01, 8'h01, 8'h3C};

    // R1 reset, R11 fetch/execute sequence, R5 jump landing
    hold_reset();
    chk("R1 no write during reset", bus_we, 0);
    mem[8'h40] = 8'h21;
    emit(8'h41); emit(8'h11); emit(8'h51); emit(8'h22); emit(8'h38);
    emit(8'h92); emit(8'h81); emit(8'h93);
    emit(8'h41); emit(8'h05); emit(8'h51); emit(8'h05); emit(8'h39);
    emit(8'hAC); p = pw; emit(8'h00);
    emit(8'h41); emit(8'hB1); emit(8'h94); mem[p] = pw;
    emit(8'h41); emit(8'h0F); emit(8'h51); emit(8'hF0); emit(8'h14);
    emit(8'h81); emit(8'h95);
    emit(8'h41); emit(8'h30); emit(8'h48); emit(8'h05); emit(8'h96);
    emit(8'h54); emit(8'h0C); emit(8'h81); emit(8'h97);
    emit(8'h51); emit(8'h40); emit(8'h41); emit(8'h10); emit(8'hC8); emit(8'h98);
    emit(8'hD6); emit(8'h81); emit(8'h99);
    emit(8'h41); emit(8'hFF); emit(8'h51); emit(8'h01); emit(8'h38); emit(8'h88);
    emit(8'hA3); p = pw; emit(8'h00);
    emit(8'h41); emit(8'hC1); emit(8'h9A); mem[p] = pw;
    emit(8'h51); p = pw; emit(8'h00); emit(8'h21);
    emit(8'h41); emit(8'hEE); emit(8'h9B); mem[p] = pw;
    emit(8'h41); emit(8'h77); emit(8'h9C); emit(8'h9F);
    emit(8'h37); emit(8'hA4); p = pw; emit(8'h00);
    emit(8'h41); emit(8'hE1); emit(8'h9D); mem[p] = pw;
    emit(8'h41); emit(8'h5C); emit(8'h9E);
    p = pw; emit(8'h61); emit(p);
    rst = 1'b0;
    #1;
    chk("R1 first fetch address", bus_addr, 8'h00);
    chk("R1 no write after reset", bus_we, 0);
    @(negedge clk);
    chk("R11 execute reads jump operand", bus_addr, 8'h01);
    @(negedge clk);
    chk("R5 jump lands at target", bus_addr, 8'h80);
    run(200);
    chk("R2 discard keeps A", mem[2], 8'h11);
    chk("R8 swap exposes B", mem[3], 8'h22);
    chk("R10 bnz not taken skips target", mem[4], 8'hB1);
    chk("R2 destination B", mem[5], 8'hFF);
    chk("R5 add immediate", mem[6], 8'h35);
    chk("R5 or immediate to B", mem[7], 8'h3D);
    chk("R6 add memory operand", mem[8], 8'h31);
    chk("R6 xor memory operand to B", mem[9], 8'h10);
    chk("R8 clc then bcs not taken", mem[10], 8'hC1);
    chk("R2 destination IP skips store", mem[11], 8'h00);
    chk("R2 destination IP lands", mem[12], 8'h77);
    chk("R7 store to address 0F", mem[15], 8'h77);
    chk("R7 no stray store above zero page", mem[8'h1F], 8'h00);
    chk("R10 bz taken skips store", mem[13], 8'h00);
    chk("R10 bz taken lands", mem[14], 8'h5C);

    // R9 soft reset loop
    hold_reset();
    mem[0] = 8'h9A; mem[1] = 8'h81; mem[2] = 8'h9B; mem[3] = 8'hA1; mem[4] = 8'h80;
    mem[5] = 8'h41; mem[6] = 8'hEE; mem[7] = 8'h9C; mem[8] = 8'h61; mem[9] = 8'h08;
    mem[10] = 8'hAA; mem[11] = 8'hAA;
    emit(8'h51); emit(8'h0D); emit(8'hC2); emit(8'h9D);
    emit(8'h41); emit(8'hFF); emit(8'h51); emit(8'h01); emit(8'h38);
    emit(8'h41); emit(8'h33); emit(8'h51); emit(8'h44); emit(8'h8F);
    run(200);
    chk("R9 soft reset clears A", mem[10], 8'h00);
    chk("R9 soft reset clears B", mem[11], 8'h00);
    chk("R9 soft reset clears carry", mem[12], 8'h00);
    chk("R9 soft reset restarts at 0", (mem[13] >= 8'd2) ? 1 : 0, 1);

    // R3/R4 sweep
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 8; k++)
        for (int ci = 0; ci < 2; ci++)
          alu_case(op, va[k], vb[k], ci);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule